// File: doc/BRIEF.md
# AXI Port Abort Flusher

This block sits beside a high-performance AXI-style memory port that cannot itself be reset. It watches every address, data and response handshake on the port and keeps its own running count of read bursts, write bursts still owed data, and write bursts still owed a response. When a transfer has to be abandoned, an abort pulse from the slower control clock domain starts a flush. The block then pulls all outstanding read data out of the port and discards it. It also pads every open write burst with a single dummy beat that carries the last-beat flag. The flush ends once its own counts reach zero.

The block does not drive the port by itself. It produces override signals (read ready, write valid, write last and write ID), and the surrounding logic ORs them into the port. The handshakes the port actually sees come back to the block as inputs. A done pulse is returned to the control domain. A sticky mismatch flag reports when the port's own occupancy counters claim to be empty while the internal counts are not. The flush runs to completion whatever that flag says. The fast-domain reset only freezes the block; it never discards the counts.

Top module: `axi_flush_ctl`

## Requirements
- R1: Three counters track traffic when `hrst` is low. The read count rises on each accepted read address and falls on each accepted read beat that has `rlast` set. The write-address count rises on each accepted write address and falls on each accepted write beat that has `wlast` set; that same beat raises the write count. The write count falls on each accepted write response. `dbg` shows them as bits 21:16 write-address count, bits 15:8 write count and bits 7:0 read count.
- R2: An abort pulse on `abort_m` reaches the fast domain through a pulse synchronizer. If the block is idle, it is accepted and `busy` goes high.
- R3: During a flush, `rready_frc` is high exactly while `busy` is high and the read count is nonzero. The outstanding read data is drained to zero.
- R4: During a flush, `wvalid_frc` rises only when the write-address count is nonzero. It drops for at least one cycle after each accepted beat, and `wlast_frc` is high whenever `wvalid_frc` is. The write-address count is drained to zero.
- R5: A flush ends when all three counts are zero and no dummy beat is pending. `busy` then falls with `dbg` equal to zero, and exactly one single-cycle `done_m` pulse follows in the `mclk` domain. An abort with nothing outstanding also produces exactly one pulse.
- R6: `mismatch` is set during a flush in either of two cases: the read count is nonzero while `port_rcount` and `port_racount` are both zero, or the write-address count is nonzero while `port_wacount` is zero. It stays set, the flush still completes, and it is cleared only when the next abort is accepted.
- R7: While `hrst` is high, handshakes and aborts are ignored, and all counters, state and override outputs hold their values. Nothing is cleared when `hrst` falls.
- R8: `wid_frc` equals the `awid` of the most recently accepted write address.
- R9: After `mrst`, `done_m` is low; at power-up `busy`, `mismatch`, the overrides and `dbg` are all zero.
- R10: An abort that arrives while a flush is in progress is ignored. It starts no second flush and produces no second `done_m` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Port clock |
| hrst | input | 1 | Fast-domain freeze (active high, clears nothing) |
| mclk | input | 1 | Control clock |
| mrst | input | 1 | Control-domain synchronous reset |
| abort_m | input | 1 | Abort request pulse (mclk) |
| done_m | output | 1 | Flush complete pulse (mclk) |
| arvalid | input | 1 | Observed read address valid |
| arready | input | 1 | Observed read address ready |
| rvalid | input | 1 | Observed read data valid |
| rready | input | 1 | Observed read data ready |
| rlast | input | 1 | Observed read last beat |
| awvalid | input | 1 | Observed write address valid |
| awready | input | 1 | Observed write address ready |
| awid | input | ID_W | Observed write address ID |
| wvalid | input | 1 | Observed write data valid |
| wready | input | 1 | Observed write data ready |
| wlast | input | 1 | Observed write last beat |
| bvalid | input | 1 | Observed write response valid |
| bready | input | 1 | Observed write response ready |
| port_rcount | input | PRC_W | Port read data FIFO occupancy |
| port_racount | input | PRA_W | Port read address FIFO occupancy |
| port_wacount | input | PWA_W | Port write address FIFO occupancy |
| rready_frc | output | 1 | Read ready override |
| wvalid_frc | output | 1 | Dummy write beat valid |
| wlast_frc | output | 1 | Dummy write beat last flag |
| wid_frc | output | ID_W | ID for dummy write beats |
| busy | output | 1 | Flush in progress |
| mismatch | output | 1 | Sticky counter disagreement flag |
| dbg | output | AWC_W+WC_W+RC_W | Counter snapshot {write-address, write, read} |

## Verification
Several rules are checked by assertions on every cycle. The read-ready override tracks the busy state and the read count. Dummy beats always carry the last flag, start only when writes are open, and leave a gap after each accepted beat. When busy falls, every count is zero. The done pulse lasts one cycle. The mismatch flag does not drop mid-flush, and the state is frozen while `hrst` is high. Other behaviour needs the bench's scenarios. These cover counting across mixed read and write loads with different burst lengths, the mismatch path with lying port counters, and the ID carried by dummy beats. They also cover an abort dropped during the freeze and a second abort ignored mid-flush, which rely on the cross-domain pulses that the scenarios drive.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_RUN  = 1'b1
  } fl_state_t;
endpackage

// File: rtl/flush_updown.sv
// Outstanding-item counter; frozen when en is low.
module flush_updown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_n
);
  logic [W-1:0] cnt_q = '0;

  always_comb begin
    cnt_n = cnt_q;
    if (en) cnt_n = cnt_q + W'(inc) - W'(dec);
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/flush_pulse_xing.sv
// Toggle-based pulse crossing. Power-up values come from initializers so
// that no reset on either side can create a false edge.
module flush_pulse_xing #(
  parameter int STAGES = 3
) (
  input  logic src_clk,
  input  logic src_pulse,
  input  logic dst_clk,
  output logic dst_pulse
);
  logic              tog   = 1'b0;
  logic [STAGES-1:0] sync  = '0;
  logic              pls_q = 1'b0;

  always_ff @(posedge src_clk) begin
    if (src_pulse) tog <= ~tog;
  end

  always_ff @(posedge dst_clk) begin
    sync  <= {sync[STAGES-2:0], tog};
    pls_q <= sync[STAGES-1] ^ sync[STAGES-2];
  end

  assign dst_pulse = pls_q;
endmodule

// File: rtl/flush_seq.sv
// Flush sequencer: state, read drain, dummy write beats, mismatch flag.
module flush_seq
  import flush_pkg::*;
#(
  parameter int AWC_W = 6,
  parameter int WC_W  = 8,
  parameter int RC_W  = 8,
  parameter int PRC_W = 8,
  parameter int PRA_W = 3,
  parameter int PWA_W = 6
) (
  input  logic             clk,
  input  logic             en,
  input  logic             abort_h,
  input  logic [RC_W-1:0]  r_cnt,
  input  logic [RC_W-1:0]  r_cnt_n,
  input  logic [AWC_W-1:0] aw_cnt,
  input  logic [WC_W-1:0]  w_cnt,
  input  logic             wready,
  input  logic [PRC_W-1:0] port_rcount,
  input  logic [PRA_W-1:0] port_racount,
  input  logic [PWA_W-1:0] port_wacount,
  output logic             rready_frc,
  output logic             wvalid_frc,
  output logic             wlast_frc,
  output logic             busy,
  output logic             mismatch,
  output logic             done_h
);
  fl_state_t st   = FL_IDLE;
  fl_state_t st_n;
  logic      rr_q = 1'b0;
  logic      wv_q = 1'b0;
  logic      wl_q = 1'b0;
  logic      mm_q = 1'b0;
  logic      dn_q = 1'b0;
  logic      all_clear;
  logic      mm_cond;

  assign all_clear = (r_cnt == '0) && (aw_cnt == '0) && (w_cnt == '0) && !wv_q;
  assign mm_cond   = ((r_cnt != '0) && (port_rcount == '0) && (port_racount == '0)) ||
                     ((aw_cnt != '0) && (port_wacount == '0));

  always_comb begin
    st_n = st;
    if (en) begin
      case (st)
        FL_IDLE: if (abort_h) st_n = FL_RUN;
        FL_RUN:  if (all_clear) st_n = FL_IDLE;
        default: st_n = FL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    dn_q <= 1'b0;
    if (en) begin
      st   <= st_n;
      dn_q <= (st == FL_RUN) && (st_n == FL_IDLE);
      rr_q <= (st_n == FL_RUN) && (r_cnt_n != '0);
      if (wv_q && wready) begin
        wv_q <= 1'b0;
        wl_q <= 1'b0;
      end else if ((st == FL_RUN) && (aw_cnt != '0)) begin
        wv_q <= 1'b1;
        wl_q <= 1'b1;
      end
      if ((st == FL_IDLE) && abort_h) mm_q <= 1'b0;
      else if ((st == FL_RUN) && mm_cond) mm_q <= 1'b1;
    end
  end

  assign rready_frc = rr_q;
  assign wvalid_frc = wv_q;
  assign wlast_frc  = wl_q;
  assign busy       = (st == FL_RUN);
  assign mismatch   = mm_q;
  assign done_h     = dn_q;
endmodule

// File: rtl/axi_flush_ctl.sv
module axi_flush_ctl
  import flush_pkg::*;
#(
  parameter int ID_W   = 6,
  parameter int AWC_W  = 6,
  parameter int WC_W   = 8,
  parameter int RC_W   = 8,
  parameter int PRC_W  = 8,
  parameter int PRA_W  = 3,
  parameter int PWA_W  = 6,
  parameter int STAGES = 3
) (
  input  logic                        hclk,
  input  logic                        hrst,
  input  logic                        mclk,
  input  logic                        mrst,
  input  logic                        abort_m,
  output logic                        done_m,
  input  logic                        arvalid,
  input  logic                        arready,
  input  logic                        rvalid,
  input  logic                        rready,
  input  logic                        rlast,
  input  logic                        awvalid,
  input  logic                        awready,
  input  logic [ID_W-1:0]             awid,
  input  logic                        wvalid,
  input  logic                        wready,
  input  logic                        wlast,
  input  logic                        bvalid,
  input  logic                        bready,
  input  logic [PRC_W-1:0]            port_rcount,
  input  logic [PRA_W-1:0]            port_racount,
  input  logic [PWA_W-1:0]            port_wacount,
  output logic                        rready_frc,
  output logic                        wvalid_frc,
  output logic                        wlast_frc,
  output logic [ID_W-1:0]             wid_frc,
  output logic                        busy,
  output logic                        mismatch,
  output logic [AWC_W+WC_W+RC_W-1:0]  dbg
);
  logic             en;
  logic             ar_hs, r_end, aw_hs, w_end, b_hs;
  logic [RC_W-1:0]  r_cnt, r_cnt_n;
  logic [AWC_W-1:0] aw_cnt, aw_cnt_n;
  logic [WC_W-1:0]  w_cnt, w_cnt_n;
  logic [ID_W-1:0]  id_q = '0;
  logic             abort_src, abort_h, done_h, done_x;
  logic             done_q;

  assign en    = !hrst;
  assign ar_hs = arvalid && arready;
  assign r_end = rvalid && rready && rlast;
  assign aw_hs = awvalid && awready;
  assign w_end = wvalid && wready && wlast;
  assign b_hs  = bvalid && bready;

  flush_updown #(.W(RC_W)) u_rcnt (
    .clk(hclk), .en(en), .inc(ar_hs), .dec(r_end), .cnt(r_cnt), .cnt_n(r_cnt_n));
  flush_updown #(.W(AWC_W)) u_awcnt (
    .clk(hclk), .en(en), .inc(aw_hs), .dec(w_end), .cnt(aw_cnt), .cnt_n(aw_cnt_n));
  flush_updown #(.W(WC_W)) u_wcnt (
    .clk(hclk), .en(en), .inc(w_end), .dec(b_hs), .cnt(w_cnt), .cnt_n(w_cnt_n));

  always_ff @(posedge hclk) begin
    if (en && aw_hs) id_q <= awid;
  end

  assign abort_src = abort_m && !mrst;

  flush_pulse_xing #(.STAGES(STAGES)) u_abort_x (
    .src_clk(mclk), .src_pulse(abort_src), .dst_clk(hclk), .dst_pulse(abort_h));

  flush_seq #(
    .AWC_W(AWC_W), .WC_W(WC_W), .RC_W(RC_W),
    .PRC_W(PRC_W), .PRA_W(PRA_W), .PWA_W(PWA_W)
  ) u_seq (
    .clk(hclk), .en(en), .abort_h(abort_h),
    .r_cnt(r_cnt), .r_cnt_n(r_cnt_n), .aw_cnt(aw_cnt), .w_cnt(w_cnt),
    .wready(wready), .port_rcount(port_rcount), .port_racount(port_racount),
    .port_wacount(port_wacount), .rready_frc(rready_frc), .wvalid_frc(wvalid_frc),
    .wlast_frc(wlast_frc), .busy(busy), .mismatch(mismatch), .done_h(done_h));

  flush_pulse_xing #(.STAGES(STAGES)) u_done_x (
    .src_clk(hclk), .src_pulse(done_h), .dst_clk(mclk), .dst_pulse(done_x));

  always_ff @(posedge mclk) begin
    if (mrst) done_q <= 1'b0;
    else      done_q <= done_x;
  end

  assign done_m  = done_q;
  assign wid_frc = id_q;
  assign dbg     = {aw_cnt, w_cnt, r_cnt};
endmodule

// File: rtl/axi_flush_chk.sv
module axi_flush_chk #(
  parameter int AWC_W = 6,
  parameter int WC_W  = 8,
  parameter int RC_W  = 8
) (
  input logic                       hclk,
  input logic                       hrst,
  input logic                       mclk,
  input logic                       mrst,
  input logic                       done_m,
  input logic                       busy,
  input logic                       mismatch,
  input logic                       rready_frc,
  input logic                       wvalid_frc,
  input logic                       wlast_frc,
  input logic                       wready,
  input logic [AWC_W+WC_W+RC_W-1:0] dbg
);
  localparam int DW = AWC_W + WC_W + RC_W;

  logic [AWC_W-1:0] aw_v;
  logic [RC_W-1:0]  r_v;
  assign aw_v = dbg[DW-1 -: AWC_W];
  assign r_v  = dbg[RC_W-1:0];

  p_rready_track_r3: assert property (@(posedge hclk) disable iff (hrst)
    rready_frc == (busy && (r_v != '0)));

  p_last_with_valid_r4: assert property (@(posedge hclk) disable iff (hrst)
    wvalid_frc |-> wlast_frc);

  p_single_beat_r4: assert property (@(posedge hclk) disable iff (hrst)
    (wvalid_frc && wready) |=> !wvalid_frc);

  p_beat_needs_open_r4: assert property (@(posedge hclk) disable iff (hrst)
    $rose(wvalid_frc) |-> ($past(aw_v) != '0));

  p_clean_end_r5: assert property (@(posedge hclk) disable iff (hrst)
    $fell(busy) |-> (dbg == '0));

  p_done_width_r5: assert property (@(posedge mclk) disable iff (mrst)
    done_m |=> !done_m);

  p_mismatch_sticky_r6: assert property (@(posedge hclk) disable iff (hrst)
    (mismatch && busy) |=> mismatch);

  // R7: state observed after a frozen cycle equals state before it
  logic          seen   = 1'b0;
  logic          hr_d   = 1'b0;
  logic          bz_d   = 1'b0;
  logic [DW-1:0] dbg_d  = '0;

  always_ff @(posedge hclk) begin
    if (seen && hr_d) begin
      p_freeze_r7: assert ((dbg == dbg_d) && (busy == bz_d))
        else $error("R7 freeze violated");
    end
    seen  <= 1'b1;
    hr_d  <= hrst;
    bz_d  <= busy;
    dbg_d <= dbg;
  end
endmodule

bind axi_flush_ctl axi_flush_chk #(
  .AWC_W(AWC_W), .WC_W(WC_W), .RC_W(RC_W)
) u_chk (
  .hclk(hclk), .hrst(hrst), .mclk(mclk), .mrst(mrst), .done_m(done_m),
  .busy(busy), .mismatch(mismatch), .rready_frc(rready_frc),
  .wvalid_frc(wvalid_frc), .wlast_frc(wlast_frc), .wready(wready), .dbg(dbg)
);

// File: tb/tb_axi_flush_ctl.sv
`timescale 1ns/1ps
module tb_axi_flush_ctl;
  logic hclk = 1'b0;
  logic mclk = 1'b0;
  logic hrst = 1'b1;
  logic mrst = 1'b1;
  logic abort_m = 1'b0;
  logic done_m;
  logic arvalid = 1'b0, arready = 1'b0;
  logic rvalid = 1'b0, rlast = 1'b0;
  logic awvalid = 1'b0, awready = 1'b0;
  logic [5:0] awid = '0;
  logic wready = 1'b1;
  logic bvalid = 1'b0;
  logic bready = 1'b1;
  logic [7:0] port_rcount = '0;
  logic [2:0] port_racount = '0;
  logic [5:0] port_wacount = '0;
  logic rready_frc, wvalid_frc, wlast_frc, busy, mismatch;
  logic [5:0] wid_frc;
  logic [21:0] dbg;
  logic p_rready, p_wvalid, p_wlast;

  assign p_rready = rready_frc;
  assign p_wvalid = wvalid_frc;
  assign p_wlast  = wlast_frc;

  always #5 hclk = ~hclk;
  initial begin
    #2;
    forever #5 mclk = ~mclk;
  end

  axi_flush_ctl dut (
    .hclk(hclk), .hrst(hrst), .mclk(mclk), .mrst(mrst),
    .abort_m(abort_m), .done_m(done_m),
    .arvalid(arvalid), .arready(arready), .rvalid(rvalid), .rready(p_rready),
    .rlast(rlast), .awvalid(awvalid), .awready(awready), .awid(awid),
    .wvalid(p_wvalid), .wready(wready), .wlast(p_wlast),
    .bvalid(bvalid), .bready(bready),
    .port_rcount(port_rcount), .port_racount(port_racount), .port_wacount(port_wacount),
    .rready_frc(rready_frc), .wvalid_frc(wvalid_frc), .wlast_frc(wlast_frc),
    .wid_frc(wid_frc), .busy(busy), .mismatch(mismatch), .dbg(dbg));

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int rd_pend = 0, wa_pend = 0, b_pend = 0;
  int rbeats = 1;
  logic srv_en = 1'b1;
  logic zero_port = 1'b0;
  logic finished = 1'b0;

  // stimulus table: reads, writes, beats per read burst, port counters forced empty
  localparam int NV = 5;
  localparam int V_RD[NV]    = '{2, 0, 0, 3, 1};
  localparam int V_WR[NV]    = '{0, 2, 0, 3, 1};
  localparam int V_BEATS[NV] = '{1, 1, 1, 2, 4};
  localparam int V_ZERO[NV]  = '{0, 0, 0, 1, 0};

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge mclk) if (done_m) done_cnt++;

  task automatic port_model();
    logic hs_r = 1'b0, hs_w = 1'b0, wl = 1'b0, hs_b = 1'b0;
    int beat = 0;
    forever begin
      @(negedge hclk);
      if (hs_r) begin
        if (beat == rbeats - 1) begin beat = 0; rd_pend--; end
        else beat++;
      end
      if (hs_w && wl) begin wa_pend--; b_pend++; end
      if (hs_b) b_pend--;
      rvalid = srv_en && (rd_pend > 0);
      rlast  = (beat == rbeats - 1);
      bvalid = (b_pend > 0);
      port_wacount = zero_port ? 6'd0 : 6'(wa_pend);
      port_rcount  = zero_port ? 8'd0 : 8'(rd_pend * rbeats);
      #1;
      hs_r = rvalid && p_rready;
      hs_w = p_wvalid && wready;
      wl   = p_wlast;
      hs_b = bvalid && bready;
    end
  endtask

  task automatic issue_reads(input int n, input logic counted);
    for (int i = 0; i < n; i++) begin
      @(negedge hclk); arvalid = 1'b1; arready = 1'b1;
      @(negedge hclk); arvalid = 1'b0; arready = 1'b0;
      if (counted) rd_pend++;
    end
  endtask

  task automatic issue_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge hclk); awvalid = 1'b1; awready = 1'b1; awid = 6'(16 + i);
      @(negedge hclk); awvalid = 1'b0; awready = 1'b0;
      wa_pend++;
    end
  endtask

  task automatic send_abort();
    @(negedge mclk); abort_m = 1'b1;
    @(negedge mclk); abort_m = 1'b0;
  endtask

  // run one flush and observe it
  task automatic run_flush(output logic bz_seen, output int bad_last,
                           output int back2back, output int dn);
    int start = done_cnt;
    logic prev_wv = 1'b0;
    bz_seen = 1'b0; bad_last = 0; back2back = 0;
    send_abort();
    for (int c = 0; c < 400; c++) begin
      @(negedge hclk);
      if (busy) bz_seen = 1'b1;
      if (wvalid_frc && !wlast_frc) bad_last++;
      if (wvalid_frc && prev_wv) back2back++;
      prev_wv = wvalid_frc;
      if (done_cnt > start && !busy) break;
    end
    repeat (10) @(negedge hclk);
    dn = done_cnt - start;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic bz; int bl, bb, dn; int d0;
    fork port_model(); join_none
    repeat (6) @(negedge mclk);
    mrst = 1'b0;
    @(negedge hclk); hrst = 1'b0;
    repeat (3) @(negedge hclk);
    // R9 reset state
    chk(done_m == 1'b0, "R9", "done_m", done_m, 0);
    chk(busy == 1'b0, "R9", "busy", busy, 0);
    chk(mismatch == 1'b0, "R9", "mismatch", mismatch, 0);
    chk(dbg == 22'd0, "R9", "dbg", dbg, 0);
    chk(!rready_frc && !wvalid_frc, "R9", "overrides", {rready_frc, wvalid_frc}, 0);

    for (int v = 0; v < NV; v++) begin
      rbeats = V_BEATS[v];
      issue_reads(V_RD[v], 1'b1);
      issue_writes(V_WR[v]);
      @(negedge hclk);
      chk(dbg == {6'(V_WR[v]), 8'd0, 8'(V_RD[v])}, "R1", "dbg after issue",
          dbg, {6'(V_WR[v]), 8'd0, 8'(V_RD[v])});
      if (V_WR[v] > 0)
        chk(wid_frc == 6'(16 + V_WR[v] - 1), "R8", "wid_frc", wid_frc, 16 + V_WR[v] - 1);
      zero_port = (V_ZERO[v] != 0);
      run_flush(bz, bl, bb, dn);
      zero_port = 1'b0;
      chk(bz, "R2", "busy seen", bz, 1);
      chk(dn == 1, "R5", "done pulses", dn, 1);
      chk(dbg == 22'd0 && !busy, "R5", "dbg at end", dbg, 0);
      chk(rd_pend == 0, "R3", "reads left at port", rd_pend, 0);
      chk(wa_pend == 0 && b_pend == 0, "R4", "writes left at port", wa_pend + b_pend, 0);
      chk(bl == 0, "R4", "beat without last", bl, 0);
      chk(bb == 0, "R4", "back-to-back dummy beats", bb, 0);
      chk(mismatch == (V_ZERO[v] != 0), "R6", "mismatch", mismatch, V_ZERO[v]);
    end

    // R7: freeze input
    issue_reads(2, 1'b1);
    @(negedge hclk);
    hrst = 1'b1;
    issue_reads(1, 1'b0);
    d0 = done_cnt;
    send_abort();
    repeat (12) @(negedge hclk);
    chk(dbg == 22'd2, "R7", "dbg during freeze", dbg, 2);
    chk(!busy, "R7", "abort ignored in freeze", busy, 0);
    hrst = 1'b0;
    repeat (3) @(negedge hclk);
    chk(dbg == 22'd2, "R7", "dbg kept after freeze", dbg, 2);
    chk(done_cnt == d0 && !busy, "R7", "no flush from frozen abort", done_cnt - d0, 0);

    // R10: second abort during a flush
    srv_en = 1'b0;
    d0 = done_cnt;
    send_abort();
    for (int c = 0; c < 30 && !busy; c++) @(negedge hclk);
    chk(busy, "R2", "busy after abort", busy, 1);
    send_abort();
    repeat (12) @(negedge hclk);
    chk(busy && rready_frc, "R3", "rready held while reads open", rready_frc, 1);
    srv_en = 1'b1;
    for (int c = 0; c < 100; c++) begin
      @(negedge hclk);
      if (done_cnt > d0 && !busy) break;
    end
    repeat (30) @(negedge hclk);
    chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
    chk(!busy && dbg == 22'd0, "R10", "idle after single flush", busy, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule